// File: doc/BRIEF.md
# Serial Debug Access Port with Streaming Word Reads

This block is the target side of a three-wire serial debug link. An external host drives the serial clock and the data-in line and reads the data-out line. Every frame is started and paced by the host. The port recognises a word-read command and a word-write command. It reaches target memory by stealing bus cycles through a request/acknowledge handshake. The read command streams: each frame after the first address brings in the next address and returns the word fetched from the address before it. The reserved address 0xFFFF closes the stream.

The serial clock is brought into the bus-clock domain through a short synchroniser. It may toggle as fast as one bit per four bus cycles. A mode input is captured while reset is held and stays frozen afterwards; with it low the port stays dormant.

FSM states: `ST_OFF` (dormant), `ST_CMD` (8-bit command frame), `ST_RD_ADDR` (first read address), `ST_STREAM` (address in, word out), `ST_WR_ADDR` and `ST_WR_DATA`. The transitions are:
- `ST_OFF` goes to `ST_CMD` when the port is enabled.
- `ST_CMD` goes to `ST_RD_ADDR` on 0xE8 and to `ST_WR_ADDR` on 0xC8. Any other value stays in `ST_CMD`.
- `ST_RD_ADDR` goes to `ST_STREAM`.
- `ST_STREAM` stays in `ST_STREAM` on an ordinary address and goes to `ST_CMD` on 0xFFFF.
- `ST_WR_ADDR` goes to `ST_WR_DATA`, and `ST_WR_DATA` goes to `ST_CMD`.

Top module: `dbg_spi_port`

## Requirements
- R1: The mode input is captured during reset. A 1 enables the port. With a 0, data-out stays 0 and no memory request is ever made, even if the mode input later changes without a new reset.
- R2: Every frame is shifted most significant bit first. The port samples data-in at each registered rising edge of the serial clock. It moves data-out to the next bit within three bus cycles of that edge, so a host clocking at one bit per four bus cycles (two high, two low) and sampling just before each rising edge reads correct data.
- R3: The command 0xE8 followed by a 16-bit address starts a read stream. In each following 16-bit frame, data-in carries the next address and data-out carries the word read from the address of the frame before.
- R4: In a stream, address 0xFFFF starts no memory access. That frame returns the word of the last real address, and the next frame is an 8-bit command.
- R5: The command 0xC8 takes a 16-bit address frame and then a 16-bit data frame. It then issues exactly one request with write enable high carrying that address and data, and returns to command decode. Data-out is 0 during all three frames.
- R6: Any command value other than 0xE8 or 0xC8 causes no memory access, and the next 8-bit frame is decoded as a command.
- R7: A memory request stays high, with its address, write enable and write data unchanged, until acknowledge. At most one request is outstanding. Read data is taken on the acknowledge cycle.
- R8: A fetched word is loaded for output LAT bus cycles after the last rising edge of its address frame is registered (LAT = 8, or 21 with EXT_BUS set). With a host at one bit per four cycles, an idle gap of LAT bus cycles between frames is enough for the word to appear.
- R9: If the first rising edge of a data frame is registered before its word is loaded (for example, with an idle gap of LAT-3 cycles or none), the frame returns 0x0000 and the overrun output sets. Overrun stays set until reset.
- R10: After reset, data-out, the memory request and overrun are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel | input | 1 | Port enable, captured while reset is held |
| sck | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| mem_req | output | 1 | Memory cycle-steal request |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Write enable for the request |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completion pulse |
| overrun | output | 1 | Sticky flag: a data frame began before its word was ready |

## Verification
Two events can land in the same bus cycle: the fetch timer declaring the word ready, and the registered first rising edge of the next data frame. When they coincide, the edge wins and the frame counts as an overrun. The bench provokes this by setting the idle gap between the address frame and the data frame to exactly LAT cycles, to LAT-3 cycles (where the two events meet) and to zero. In each case it judges the returned word against the arithmetic memory image and checks the overrun output. The closing 0xFFFF frame is checked for both its returned word and the absence of any new memory request.

// File: rtl/dbg_spi_pkg.sv
package dbg_spi_pkg;
    localparam int WORD_W  = 16;
    localparam int CMD_W   = 8;
    localparam int LAT_INT = 8;
    localparam int LAT_EXT = 21;

    localparam logic [CMD_W-1:0]  CMD_RD_STREAM = 8'hE8;
    localparam logic [CMD_W-1:0]  CMD_WR_WORD   = 8'hC8;
    localparam logic [WORD_W-1:0] ADDR_END      = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_CMD,
        ST_RD_ADDR,
        ST_STREAM,
        ST_WR_ADDR,
        ST_WR_DATA
    } port_state_e;
endpackage

// File: rtl/dspi_sync.sv
module dspi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic sdi_in,
    output logic sck_rise,
    output logic sdi_out
);
    logic [STAGES:0]   sck_p;
    logic [STAGES-1:0] sdi_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p <= '0;
            sdi_p <= '0;
        end else begin
            sck_p[0] <= sck_in;
            sdi_p[0] <= sdi_in;
            for (int i = 1; i <= STAGES; i++) sck_p[i] <= sck_p[i-1];
            for (int i = 1; i < STAGES; i++)  sdi_p[i] <= sdi_p[i-1];
        end
    end

    // data sample aligned with the clock stage that flags the edge
    assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
    assign sdi_out  = sdi_p[STAGES-1];
endmodule

// File: rtl/dspi_mem_if.sv
module dspi_mem_if #(
    parameter int LAT = 8,
    parameter int AW  = 16,
    parameter int DW  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_we,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_wdata,
    output logic          rd_ready,
    output logic [DW-1:0] rd_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt_q;
    logic          got_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_req   <= 1'b0;
            mem_addr  <= '0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
            rd_data   <= '0;
            cnt_q     <= '0;
            got_q     <= 1'b0;
        end else if (start) begin
            mem_req   <= 1'b1;
            mem_addr  <= start_addr;
            mem_we    <= start_we;
            mem_wdata <= start_wdata;
            cnt_q     <= CW'(LAT);
            got_q     <= 1'b0;
        end else begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            if (mem_req && mem_ack) begin
                mem_req <= 1'b0;
                got_q   <= 1'b1;
                if (!mem_we) rd_data <= mem_rdata;
            end
        end
    end

    assign rd_ready = got_q && (cnt_q == '0) && !mem_we;

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !start) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    p_single_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !mem_req);
    p_no_early_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !rd_ready);
endmodule

// File: rtl/dbg_spi_port.sv
module dbg_spi_port #(
    parameter bit EXT_BUS     = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_sel,
    input  logic        sck,
    input  logic        sdi,
    output logic        sdo,
    output logic        mem_req,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    input  logic        mem_ack,
    output logic        overrun
);
    import dbg_spi_pkg::*;

    localparam int LAT = EXT_BUS ? LAT_EXT : LAT_INT;
    localparam int BCW = $clog2(WORD_W);

    port_state_e       state_q, state_d;
    logic              mode_en;
    logic              sck_rise, sdi_s;
    logic [BCW-1:0]    bit_q, last_bit;
    logic [WORD_W-1:0] rx_q, rx_word, tx_q, wa_q, rd_data;
    logic              tx_vld, frame_done, rd_ready;
    logic              mem_start, mem_start_we;
    logic [WORD_W-1:0] mem_start_addr;

    // captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) mode_en <= mode_sel;
    end

    dspi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_in   (sck),
        .sdi_in   (sdi),
        .sck_rise (sck_rise),
        .sdi_out  (sdi_s)
    );

    assign last_bit   = (state_q == ST_CMD) ? BCW'(CMD_W - 1) : BCW'(WORD_W - 1);
    assign rx_word    = {rx_q[WORD_W-2:0], sdi_s};
    assign frame_done = sck_rise && (bit_q == last_bit) && (state_q != ST_OFF);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:     if (mode_en) state_d = ST_CMD;
            ST_CMD:     if (frame_done) begin
                            if (rx_word[CMD_W-1:0] == CMD_RD_STREAM)    state_d = ST_RD_ADDR;
                            else if (rx_word[CMD_W-1:0] == CMD_WR_WORD) state_d = ST_WR_ADDR;
                        end
            ST_RD_ADDR: if (frame_done) state_d = ST_STREAM;
            ST_STREAM:  if (frame_done && rx_word == ADDR_END) state_d = ST_CMD;
            ST_WR_ADDR: if (frame_done) state_d = ST_WR_DATA;
            ST_WR_DATA: if (frame_done) state_d = ST_CMD;
            default:    state_d = ST_OFF;
        endcase
    end

    assign mem_start = frame_done && ((state_q == ST_RD_ADDR) || (state_q == ST_WR_DATA)
                                      || (state_q == ST_STREAM && rx_word != ADDR_END));
    assign mem_start_we   = (state_q == ST_WR_DATA);
    assign mem_start_addr = (state_q == ST_WR_DATA) ? wa_q : rx_word;

    dspi_mem_if #(.LAT(LAT), .AW(WORD_W), .DW(WORD_W)) u_mem (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (mem_start),
        .start_we    (mem_start_we),
        .start_addr  (mem_start_addr),
        .start_wdata (rx_word),
        .rd_ready    (rd_ready),
        .rd_data     (rd_data),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_ack     (mem_ack)
    );

    // frame counters, shift registers and the overrun flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            tx_vld  <= 1'b0;
            wa_q    <= '0;
            overrun <= 1'b0;
        end else begin
            if (sck_rise && state_q != ST_OFF) begin
                rx_q  <= rx_word;
                bit_q <= frame_done ? '0 : bit_q + 1'b1;
            end
            if (frame_done) begin
                tx_vld <= 1'b0;
                if (state_q == ST_WR_ADDR) wa_q <= rx_word;
            end else if (state_q == ST_STREAM) begin
                if (sck_rise) begin
                    if (bit_q == '0 && !tx_vld) begin
                        overrun <= 1'b1;
                        tx_q    <= '0;
                        tx_vld  <= 1'b1;
                    end else begin
                        tx_q <= {tx_q[WORD_W-2:0], 1'b0};
                    end
                end else if (!tx_vld && rd_ready && bit_q == '0) begin
                    tx_q   <= rd_data;
                    tx_vld <= 1'b1;
                end
            end
        end
    end

    assign sdo = tx_vld ? tx_q[WORD_W-1] : 1'b0;

    p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |-> (!sdo && !mem_req));
    p_mode_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_en));
    p_end_no_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && state_q == ST_STREAM && rx_word == ADDR_END) |=> (!mem_req && state_q == ST_CMD));
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_ADDR || state_q == ST_WR_DATA) |-> !sdo);
endmodule

// File: tb/tb_dbg_spi_port.sv
`timescale 1ns/1ps
module tb_dbg_spi_port;
    localparam int LAT = 8;
    localparam int H   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sel = 1'b0;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo, mem_req, mem_we, overrun;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int ntest = 0;
    int nfail = 0;
    int nreq = 0;
    int nwr = 0;
    logic [15:0] last_raddr = '0, last_waddr = '0, last_wdata = '0;
    logic [15:0] m [16];
    logic        dl = 1'b0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    dbg_spi_port dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sck(sck), .sdi(sdi), .sdo(sdo),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .overrun(overrun)
    );

    // memory: acknowledge on the second cycle a request is seen
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            if (dl) begin
                mem_ack <= 1'b1;
                dl      <= 1'b0;
                nreq    <= nreq + 1;
                if (mem_we) begin
                    m[mem_addr[3:0]] <= mem_wdata;
                    nwr        <= nwr + 1;
                    last_waddr <= mem_addr;
                    last_wdata <= mem_wdata;
                end else begin
                    mem_rdata  <= m[mem_addr[3:0]] ^ (mem_addr & 16'hFFF0);
                    last_raddr <= mem_addr;
                end
            end else begin
                dl <= 1'b1;
            end
        end
    end

    function automatic logic [15:0] rdexp(input logic [15:0] a);
        return m[a[3:0]] ^ (a & 16'hFFF0);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        ntest++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic frame(input int n, input logic [15:0] din, output logic [15:0] dout);
        dout = '0;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            sck = 1'b0;
            sdi = din[i];
            repeat (H - 1) @(negedge clk);
            @(negedge clk);
            dout[i] = sdo;
            sck = 1'b1;
            repeat (H - 1) @(negedge clk);
        end
    endtask

    task automatic gap(input int g);
        @(negedge clk);
        sck = 1'b0;
        repeat (g - 1) @(negedge clk);
    endtask

    task automatic do_reset(input logic ms);
        @(negedge clk);
        rst_n = 1'b0;
        mode_sel = ms;
        sck = 1'b0;
        sdi = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // read stream of n words, addresses base + k*step, safe gaps
    task automatic rd_stream(input logic [15:0] base, input logic [15:0] step, input int n);
        logic [15:0] d, a, prev;
        frame(8, 16'h00E8, d);
        gap(LAT + 4);
        frame(16, base, d);
        prev = base;
        for (int k = 1; k <= n; k++) begin
            a = (k == n) ? 16'hFFFF : base + 16'(k) * step;
            gap(LAT + 4);
            frame(16, a, d);
            chk(d == rdexp(prev), "R3 stream word", d, rdexp(prev));
            prev = a;
        end
        gap(LAT + 4);
    endtask

    task automatic gap_probe(input int g, input bit exp_ovr);
        logic [15:0] d;
        do_reset(1'b1);
        frame(8, 16'h00E8, d);
        gap(LAT + 4);
        frame(16, 16'h0007, d);
        if (g > 0) gap(g);
        frame(16, 16'h0008, d);
        if (exp_ovr) begin
            chk(d == 16'h0000, "R9 late word is zero", d, 16'h0000);
            chk(overrun == 1'b1, "R9 overrun set", {15'd0, overrun}, 16'h0001);
        end else begin
            chk(d == rdexp(16'h0007), "R8 word ready at LAT gap", d, rdexp(16'h0007));
            chk(overrun == 1'b0, "R8 no overrun", {15'd0, overrun}, 16'h0000);
        end
        gap(LAT + 4);
        frame(16, 16'hFFFF, d);
        chk(d == rdexp(16'h0008), "R4 final word after gap probe", d, rdexp(16'h0008));
        chk(overrun == exp_ovr, "R9 overrun sticky", {15'd0, overrun}, {15'd0, exp_ovr});
        gap(LAT + 4);
    endtask

    initial begin
        logic [15:0] d;
        int r0, w0;
        for (int i = 0; i < 16; i++) m[i] = 16'(i * 16'h9E37 + 16'h0123);

        // R10 reset state
        do_reset(1'b1);
        chk(sdo == 1'b0 && mem_req == 1'b0 && overrun == 1'b0, "R10 reset outputs",
            {13'd0, sdo, mem_req, overrun}, 16'h0000);

        // R3/R2 sweep of all low addresses
        r0 = nreq;
        rd_stream(16'h0000, 16'h0001, 16);
        chk(nreq - r0 == 16, "R7 one access per address", 16'(nreq - r0), 16'd16);
        chk(last_raddr == 16'h000F, "R2 address shifted in MSB first", last_raddr, 16'h000F);

        // R2 addresses with upper bits set
        rd_stream(16'h3A70, 16'h0111, 5);
        chk(last_raddr == 16'h3EB4, "R2 upper address bits", last_raddr, 16'h3EB4);

        // R4: terminating frame makes no access, next frame is a command
        r0 = nreq;
        frame(8, 16'h00E8, d);
        gap(LAT + 4);
        frame(16, 16'h0009, d);
        gap(LAT + 4);
        frame(16, 16'hFFFF, d);
        chk(d == rdexp(16'h0009), "R4 last real word", d, rdexp(16'h0009));
        repeat (20) @(negedge clk);
        chk(nreq - r0 == 1, "R4 no access for end address", 16'(nreq - r0), 16'd1);

        // R5 write word
        w0 = nwr;
        gap(LAT + 4);
        frame(8, 16'h00C8, d);
        gap(4);
        frame(16, 16'h0005, d);
        chk(d == 16'h0000, "R5 sdo quiet on address", d, 16'h0000);
        gap(4);
        frame(16, 16'hBEEF, d);
        chk(d == 16'h0000, "R5 sdo quiet on data", d, 16'h0000);
        repeat (12) @(negedge clk);
        chk(nwr - w0 == 1, "R5 single write", 16'(nwr - w0), 16'd1);
        chk(last_waddr == 16'h0005, "R5 write address", last_waddr, 16'h0005);
        chk(last_wdata == 16'hBEEF, "R5 write data", last_wdata, 16'hBEEF);
        frame(8, 16'h00E8, d);
        gap(LAT + 4);
        frame(16, 16'h0005, d);
        gap(LAT + 4);
        frame(16, 16'hFFFF, d);
        chk(d == 16'hBEEF, "R5 readback after write", d, 16'hBEEF);
        gap(LAT + 4);

        // R6 unknown commands
        r0 = nreq;
        frame(8, 16'h0055, d);
        gap(4);
        frame(8, 16'h00E9, d);
        gap(4);
        repeat (12) @(negedge clk);
        chk(nreq == r0, "R6 no access on unknown command", 16'(nreq - r0), 16'd0);
        rd_stream(16'h0002, 16'h0003, 3);
        chk(nreq - r0 == 3, "R6 next frame decoded as command", 16'(nreq - r0), 16'd3);
        chk(overrun == 1'b0, "R9 no overrun with safe gaps", {15'd0, overrun}, 16'h0000);

        // R8 / R9 gap probes around the ready cycle
        gap_probe(LAT, 1'b0);
        gap_probe(LAT - 3, 1'b1);
        gap_probe(0, 1'b1);
        do_reset(1'b1);
        chk(overrun == 1'b0, "R10 reset clears overrun", {15'd0, overrun}, 16'h0000);

        // R1 dormant mode
        do_reset(1'b0);
        r0 = nreq;
        for (int pass = 0; pass < 2; pass++) begin
            frame(8, 16'h00E8, d);
            gap(LAT + 4);
            frame(16, 16'h0003, d);
            gap(LAT + 4);
            frame(16, 16'h0004, d);
            chk(d == 16'h0000, "R1 sdo idle when disabled", d, 16'h0000);
            gap(LAT + 4);
            chk(nreq == r0, "R1 no access when disabled", 16'(nreq - r0), 16'd0);
            mode_sel = 1'b1;
        end
        do_reset(1'b1);
        rd_stream(16'h000A, 16'h0001, 2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            ntest++;
            nfail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 16'h0000, 16'h0001);
            $display("[TB] %0d tests run, %0d failed", ntest, nfail);
            $finish;
        end
    end
endmodule